// File: doc/BRIEF.md
# Frame-Clock Sequence Watchdog with Auto-Resync

This block watches the left/right frame clock from the master-clock domain. It measures how many master-clock cycles pass between successive rising frame edges and compares that count with a nominal frame length. The nominal length is 384 cycles when the mode input is high and 256 cycles when it is low. The accepted window around the nominal length is asymmetric, and its size depends on the mode.

Alongside the measurement, a free-running sequence phase counter steps once per master cycle and wraps at the nominal length. Downstream arithmetic uses it to schedule its work. Jitter that stays inside the window leaves this counter alone. A frame period outside the window makes the block force the counter to zero, so that it lines up with the frame edge. When that happens the block emits a one-cycle resync pulse and sets a sticky error flag.

Top module: `frame_seq_watchdog`

## Requirements
- R1: The phase output `seq_phase_o` advances by one every master cycle and wraps to 0 after reaching nominal-1. Nominal is 384 when `mode_long_i` is 1 and 256 when it is 0. After reset the phase is 0.
- R2: In long mode, a frame period of 378 to 392 master cycles inclusive is accepted. A period of 377 or less, or of 393 or more, is out of tolerance.
- R3: In short mode, a frame period of 253 to 260 master cycles inclusive is accepted. A period of 252 or less, or of 261 or more, is out of tolerance.
- R4: An out-of-tolerance period raises `resync_o` for exactly one master cycle, and `seq_phase_o` reads 0 in that cycle. Suppose the frame clock first rises before master edge k. Then the pulse is visible after edge k+2: two synchronizer flops plus one output register.
- R5: An in-tolerance period, including any jitter inside the window, produces no resync. The phase continues its count without a break.
- R6: The first rising frame edge after reset only starts measurement and never produces a resync, whatever its timing.
- R7: The period counter saturates instead of wrapping. A gap far longer than nominal always counts as out of tolerance. In long mode, a 1408-cycle gap must resync even though it is 384 modulo 1024.
- R8: `err_sticky_o` is 0 after reset. It becomes 1 together with the first resync pulse and stays 1 until reset.
- R9: `resync_o` is raised only as the result of a rising frame edge. It stays 0 in every cycle that does not follow one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Left/right frame clock, asynchronous to the master clock |
| mode_long_i | input | 1 | 1: nominal 384-cycle frame, 0: nominal 256-cycle frame |
| seq_phase_o | output | 9 | Sequence phase, 0 to nominal-1 |
| resync_o | output | 1 | One-cycle pulse when the sequence is forced to zero |
| err_sticky_o | output | 1 | Set by any resync, cleared only by reset |

## Verification
The bench builds the block with its default parameters: frame lengths of 384 and 256, the 8/6 and 4/3 tolerance margins, two synchronizer stages, and a 10-bit period counter. With a 10-bit counter a saturation corner is reachable in a few thousand cycles. That corner is a gap of 1408, which would alias to an in-window 384 if the counter wrapped. Both window edges of each mode are covered directly, and seeded random periods straddling each window exercise the transitions between accepted and rejected frames.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic {
    FSW_SHORT = 1'b0,
    FSW_LONG  = 1'b1
  } fsw_mode_e;

  // window bounds expressed as counter values (period - 1)
  function automatic int unsigned win_lo(int unsigned nom, int unsigned early);
    return nom - early - 1;
  endfunction

  function automatic int unsigned win_hi(int unsigned nom, int unsigned late);
    return nom + late - 1;
  endfunction
endpackage

// File: rtl/fsw_edge_sync.sv
module fsw_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fsw_period_meter.sv
module fsw_period_meter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             bad_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // saturated count is never accepted
  assign in_win = (cnt_q >= lo_i) && (cnt_q <= hi_i) && (cnt_q != CNT_MAX);
  assign bad_o  = rise_i & armed_q & ~in_win;
endmodule

// File: rtl/fsw_seq_counter.sv
module fsw_seq_counter #(
  parameter int unsigned PH_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            force_i,
  input  logic [PH_W-1:0] last_i,
  output logic [PH_W-1:0] phase_o,
  output logic            resync_o,
  output logic            err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o  <= '0;
      resync_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (force_i) begin
      phase_o  <= '0;
      resync_o <= 1'b1;
      err_o    <= 1'b1;
    end else begin
      resync_o <= 1'b0;
      // >= covers a mode switch that leaves phase past the new end
      phase_o  <= (phase_o >= last_i) ? '0 : phase_o + 1'b1;
    end
  end
endmodule

// File: rtl/frame_seq_watchdog.sv
module frame_seq_watchdog #(
  parameter int unsigned LONG_NOM    = 384,
  parameter int unsigned SHORT_NOM   = 256,
  parameter int unsigned LONG_LATE   = 8,
  parameter int unsigned LONG_EARLY  = 6,
  parameter int unsigned SHORT_LATE  = 4,
  parameter int unsigned SHORT_EARLY = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PH_W  = $clog2(LONG_NOM),
  localparam int unsigned CNT_W = $clog2(LONG_NOM + LONG_LATE) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_clk_i,
  input  logic            mode_long_i,
  output logic [PH_W-1:0] seq_phase_o,
  output logic            resync_o,
  output logic            err_sticky_o
);
  import fsw_pkg::*;

  localparam logic [CNT_W-1:0] L_LO = CNT_W'(win_lo(LONG_NOM, LONG_EARLY));
  localparam logic [CNT_W-1:0] L_HI = CNT_W'(win_hi(LONG_NOM, LONG_LATE));
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(win_lo(SHORT_NOM, SHORT_EARLY));
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(win_hi(SHORT_NOM, SHORT_LATE));
  localparam logic [PH_W-1:0]  L_LAST = PH_W'(LONG_NOM - 1);
  localparam logic [PH_W-1:0]  S_LAST = PH_W'(SHORT_NOM - 1);

  fsw_mode_e        mode;
  logic             frame_rise;
  logic             period_bad;
  logic [CNT_W-1:0] lo, hi;
  logic [PH_W-1:0]  last;

  assign mode = fsw_mode_e'(mode_long_i);

  always_comb begin
    if (mode == FSW_LONG) begin
      lo = L_LO; hi = L_HI; last = L_LAST;
    end else begin
      lo = S_LO; hi = S_HI; last = S_LAST;
    end
  end

  fsw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(frame_clk_i),
    .rise_o (frame_rise)
  );

  fsw_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(frame_rise),
    .lo_i  (lo),
    .hi_i  (hi),
    .bad_o (period_bad)
  );

  fsw_seq_counter #(.PH_W(PH_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (period_bad),
    .last_i  (last),
    .phase_o (seq_phase_o),
    .resync_o(resync_o),
    .err_o   (err_sticky_o)
  );
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int unsigned PH_W     = 9,
  parameter int unsigned LONG_NOM = 384
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rise_i,
  input logic [PH_W-1:0] seq_phase_o,
  input logic            resync_o,
  input logic            err_sticky_o
);
  assert_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(seq_phase_o) < LONG_NOM);

  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o);

  assert_zero_on_resync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> seq_phase_o == '0);

  assert_steady_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (resync_o || seq_phase_o == '0 || seq_phase_o == $past(seq_phase_o) + 1'b1));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);

  assert_err_with_resync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> err_sticky_o);

  assert_edge_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> $past(rise_i));
endmodule

bind frame_seq_watchdog fsw_checker #(.PH_W(PH_W), .LONG_NOM(LONG_NOM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rise_i      (frame_rise),
  .seq_phase_o (seq_phase_o),
  .resync_o    (resync_o),
  .err_sticky_o(err_sticky_o)
);

// File: tb/frame_seq_watchdog_tb.sv
module frame_seq_watchdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       mode = 1'b1;
  logic [8:0] phase;
  logic       resync;
  logic       err;

  int unsigned since = 0;
  int unsigned base = 0;
  int unsigned last_gap = 0;
  bit armed = 0;
  bit any_bad = 0;
  bit done = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 0;
    else        since <= since + 1;
  end

  frame_seq_watchdog u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_clk_i (frame),
    .mode_long_i (mode),
    .seq_phase_o (phase),
    .resync_o    (resync),
    .err_sticky_o(err)
  );

  function automatic bit in_win(int unsigned n, bit long_m);
    if (long_m) return (n >= 378) && (n <= 392);
    return (n >= 253) && (n <= 260);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(bit long_m);
    @(negedge clk);
    rst_n = 1'b0;
    frame = 1'b0;
    mode  = long_m;
    repeat (3) @(negedge clk);
    check(phase == 0, "R1", "phase in reset", int'(phase), 0);
    check(resync == 0, "R4", "resync in reset", int'(resync), 0);
    check(err == 0, "R8", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    base = 0; armed = 0; any_bad = 0; last_gap = 0;
  endtask

  task automatic idle(int unsigned n);
    bit stray = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (resync) stray = 1;
    end
    check(!stray, "R9", "resync while idle", int'(stray), 0);
  endtask

  // raise frame now; the result of the previous gap shows 3 negedges later
  task automatic rise(int unsigned gap);
    bit exp_bad;
    bit stray = 0;
    int unsigned nom;
    string tag;
    nom = mode ? 384 : 256;
    exp_bad = armed && !in_win(last_gap, mode);
    tag = !armed ? "R6" : (last_gap > 1000) ? "R7" : mode ? "R2" : "R3";
    frame = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i == gap / 2) frame = 1'b0;
      if (i == 3) begin
        check(resync == exp_bad, tag, $sformatf("resync after gap %0d", last_gap),
              int'(resync), int'(exp_bad));
        if (exp_bad) begin
          base = since;
          any_bad = 1;
        end
        check(int'(phase) == int'((since - base) % nom), exp_bad ? "R4" : "R5",
              "phase", int'(phase), int'((since - base) % nom));
        check(err == any_bad, "R8", "sticky err", int'(err), int'(any_bad));
      end else if (resync) begin
        stray = 1;
      end
    end
    check(!stray, "R4", "pulse outside expected cycle", int'(stray), 0);
    armed = 1;
    last_gap = gap;
  endtask

  initial begin
    void'($urandom(32'd5150));
    // long mode
    do_reset(1'b1);
    idle(37);
    rise(384);   // R6: first edge only arms
    rise(384);
    rise(378);
    rise(392);
    rise(384);   // R1 wrap path with all in-window
    rise(377);
    rise(384);
    rise(393);
    rise(384);
    rise(1408);  // R7: aliases to 384 if the counter wrapped
    rise(384);
    for (int k = 0; k < 30; k++) rise(370 + ($urandom % 31));
    rise(384);
    // short mode
    do_reset(1'b0);
    idle(11);
    rise(100);   // R6: odd first gap ignored
    rise(256);
    rise(253);
    rise(260);
    rise(256);
    rise(252);
    rise(256);
    rise(261);
    rise(1100);
    rise(256);
    for (int k = 0; k < 30; k++) rise(246 + ($urandom % 21));
    rise(256);
    // R6 in long mode with an early stray first edge
    do_reset(1'b1);
    rise(20);
    rise(384);
    idle(400);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule